// File: doc/BRIEF.md
# Mailbox Receive FIFO

This block is the receive side of an inter-processor mailbox. Remote cores push entries through a valid/data port. Each entry is a 64-bit message tagged with the ID of the channel it came from. The entries go into a circular FIFO. The host sees the oldest entry through three read registers: channel ID, low message word and high message word. It removes that entry by writing a pop register.

The host works out the fill level itself from a status register. That register carries the raw read pointer, the raw write pointer and a full flag, so that equal pointers can be told apart. A separate register reads back the FIFO size minus one. A not-empty interrupt has a mask bit and a write-1-to-clear status bit. Writing zero to a flush register empties the FIFO. The host port is a word-addressed register interface: reads are combinational and writes take effect on the clock edge.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the following register values hold: status (0x14) reads 0, interrupt status (0x18) reads 0, mask (0x1C) reads 0x1F, and the `irq` output is low.
- R2: The head entry of the FIFO is read back through three registers:
  - 0x0 returns the channel ID of the oldest entry, zero-extended.
  - 0x4 returns bits 31:0 of its message.
  - 0x8 returns bits 63:32 of its message.
  - Entries come out in the order they were pushed.
- R3: Writing a value with bit 0 set to 0xC pops the head entry, and the read pointer advances by one. Writing a value with bit 0 clear to 0xC has no effect.
- R4: The status register at 0x14 has these fields:
  - Bit 0 is the full flag.
  - Bits 23:16 hold the write pointer.
  - Bits 31:24 hold the read pointer.
  - All other bits are 0.
  - Both pointers run from 0 to DEPTH-1 and wrap back to 0.
- R5: When the two pointers are equal, the full flag is 1 if DEPTH entries are held and 0 if the FIFO is empty.
- R6: A push while the FIFO is full is dropped. The pointers, the full flag and the head entry stay unchanged.
- R7: A pop while the FIFO is empty has no effect on the pointers or the full flag.
- R8: Register 0x24 reads DEPTH-1.
- R9: The mask register at 0x1C is 5 bits wide.
  - Bit 0 = 0 enables the not-empty interrupt.
  - With bit 0 = 0, the interrupt status bit (0x18 bit 0, also driven on `irq`) is set on the clock edge after an edge at which the FIFO was non-empty.
  - With bit 0 = 1, the interrupt status bit never sets.
- R10: Writing 1 to bit 0 of 0x18 clears the interrupt status on that edge. If entries remain and the source is unmasked, the bit sets again on the next edge.
- R11: Writing 0 to 0x10 resets both pointers, the full flag and the interrupt status. Writing any nonzero value to 0x10 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Remote push request, one entry per cycle |
| pushChan | input | CHAN_W | Channel ID of the pushed entry |
| pushMsg | input | 64 | Message of the pushed entry |
| regAddr | input | 6 | Host register byte address |
| regWrEn | input | 1 | Host write strobe |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for `regAddr` |
| irq | output | 1 | Not-empty interrupt (interrupt status bit) |

## Verification
The hardest states to reach from the ports are the ones where the raw pointers are equal but the fill level differs. These states appear at every wrap position, not only at zero. The bench uses a depth of 5, which is not a power of two, and runs rounds of uneven push and pop bursts. This moves the equal-pointer point all the way around the ring. The bench overfills the FIFO and underflows it at those positions. Each time it compares the status word against pointers and a count kept arithmetically in the bench. The interrupt re-set after a clear is reached by clearing while an entry is still held and sampling on the two edges that follow.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;

  localparam int REG_ADDR_W = 6;

  localparam logic [REG_ADDR_W-1:0] OFS_CHAN   = 6'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_LOW    = 6'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_HIGH   = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_POP    = 6'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_FLUSH  = 6'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 6'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_IRQSTS = 6'h18;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK   = 6'h1C;
  localparam logic [REG_ADDR_W-1:0] OFS_DEPTH  = 6'h24;

  localparam int MASK_W = 5;
  localparam int PTR_FIELD_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic pop;
    logic flush;
  } fifoStrobes_t;

endpackage

// File: rtl/mbox_rx_datapath.sv
module mbox_rx_datapath
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3,
  parameter int MSG_W  = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobes_t           strobes,
  input  logic                   pushValid,
  input  logic [CHAN_W-1:0]      pushChan,
  input  logic [MSG_W-1:0]       pushMsg,
  output logic [CHAN_W-1:0]      headChan,
  output logic [MSG_W-1:0]       headMsg,
  output logic [PTR_FIELD_W-1:0] wrPtrField,
  output logic [PTR_FIELD_W-1:0] rdPtrField,
  output logic                   full,
  output logic                   empty
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0]  wrPtr, rdPtr;
  logic [CHAN_W-1:0] chanMem [DEPTH];
  logic [MSG_W-1:0]  msgMem  [DEPTH];

  logic pushOk, popOk;
  logic [IDX_W-1:0] wrNext, rdNext;

  assign empty  = (wrPtr == rdPtr) && !full;
  assign pushOk = pushValid && !full && !strobes.flush;
  assign popOk  = strobes.pop && !empty && !strobes.flush;
  assign wrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
  assign rdNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      full  <= 1'b0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      full  <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrNext;
      if (popOk)  rdPtr <= rdNext;
      if (pushOk && !popOk && (wrNext == rdPtr)) full <= 1'b1;
      else if (popOk && !pushOk)                 full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) begin
      chanMem[wrPtr] <= pushChan;
      msgMem[wrPtr]  <= pushMsg;
    end
  end

  assign headChan   = chanMem[rdPtr];
  assign headMsg    = msgMem[rdPtr];
  assign wrPtrField = PTR_FIELD_W'(wrPtr);
  assign rdPtrField = PTR_FIELD_W'(rdPtr);

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST_IDX) && (rdPtr <= LAST_IDX));

  assert_push_full_dropped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !strobes.pop && !strobes.flush) |=> ($stable(wrPtr) && full));

  assert_pop_empty_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (empty && strobes.pop && !pushValid && !strobes.flush) |=> ($stable(rdPtr) && empty));

  assert_flush_resets_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (wrPtr == '0 && rdPtr == '0 && !full));

endmodule

// File: rtl/mbox_rx_ctrl.sv
module mbox_rx_ctrl
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3,
  parameter int MSG_W  = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [REG_ADDR_W-1:0]  regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  output logic                   irqStatus,
  output fifoStrobes_t           strobes,
  input  logic [CHAN_W-1:0]      headChan,
  input  logic [MSG_W-1:0]       headMsg,
  input  logic [PTR_FIELD_W-1:0] wrPtrField,
  input  logic [PTR_FIELD_W-1:0] rdPtrField,
  input  logic                   full,
  input  logic                   empty
);

  logic [MASK_W-1:0] mask;
  logic irqClear;

  assign strobes.pop   = regWrEn && (regAddr == OFS_POP) && regWrData[0];
  assign strobes.flush = regWrEn && (regAddr == OFS_FLUSH) && (regWrData == '0);
  assign irqClear      = regWrEn && (regAddr == OFS_IRQSTS) && regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask      <= '1;
      irqStatus <= 1'b0;
    end else begin
      if (regWrEn && regAddr == OFS_MASK) mask <= regWrData[MASK_W-1:0];
      if (strobes.flush || irqClear)      irqStatus <= 1'b0;
      else if (!empty && !mask[0])        irqStatus <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      OFS_CHAN:   regRdData = 32'(headChan);
      OFS_LOW:    regRdData = headMsg[31:0];
      OFS_HIGH:   regRdData = headMsg[63:32];
      OFS_STATUS: regRdData = {rdPtrField, wrPtrField, 15'b0, full};
      OFS_IRQSTS: regRdData = {31'b0, irqStatus};
      OFS_MASK:   regRdData = 32'(mask);
      OFS_DEPTH:  regRdData = 32'(DEPTH - 1);
      default:    regRdData = '0;
    endcase
  end

  assert_irq_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |=> !irqStatus);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mask[0] && !irqStatus) |=> !irqStatus);

  assert_irq_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !mask[0] && !irqClear && !strobes.flush) |=> irqStatus);

endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [CHAN_W-1:0] pushChan,
  input  logic [63:0]       pushMsg,
  input  logic [5:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq
);

  fifoStrobes_t strobes;
  logic [CHAN_W-1:0] headChan;
  logic [63:0] headMsg;
  logic [PTR_FIELD_W-1:0] wrPtrField, rdPtrField;
  logic full, empty;

  mbox_rx_datapath #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .MSG_W(64)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pushValid(pushValid), .pushChan(pushChan), .pushMsg(pushMsg),
    .headChan(headChan), .headMsg(headMsg),
    .wrPtrField(wrPtrField), .rdPtrField(rdPtrField),
    .full(full), .empty(empty)
  );

  mbox_rx_ctrl #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .MSG_W(64)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqStatus(irq),
    .strobes(strobes), .headChan(headChan), .headMsg(headMsg),
    .wrPtrField(wrPtrField), .rdPtrField(rdPtrField),
    .full(full), .empty(empty)
  );

endmodule

// File: tb/mbox_rx_fifo_test.sv
`timescale 1ns/1ps
module mbox_rx_fifo_test;

  localparam int DEPTH = 5;
  localparam int CHAN_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [CHAN_W-1:0] pushChan = '0;
  logic [63:0] pushMsg = '0;
  logic [5:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench model
  int mWr = 0, mRd = 0, mCount = 0, seqNo = 0;
  logic [63:0] mMsg [DEPTH];
  logic [CHAN_W-1:0] mChan [DEPTH];

  always #2.5 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushChan(pushChan),
    .pushMsg(pushMsg), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic push();
    logic [63:0] m;
    logic [CHAN_W-1:0] c;
    m = {~(32'hA5000000 + 32'(seqNo)), 32'h5A000000 + 32'(seqNo)};
    c = CHAN_W'(seqNo % 8);
    seqNo++;
    @(negedge clk);
    pushValid = 1'b1; pushMsg = m; pushChan = c;
    @(negedge clk);
    pushValid = 1'b0;
    if (mCount < DEPTH) begin
      mMsg[mWr] = m; mChan[mWr] = c;
      mWr = (mWr + 1) % DEPTH; mCount++;
    end
  endtask

  task automatic pop();
    writeReg(6'h0C, 32'h1);
    if (mCount > 0) begin
      mRd = (mRd + 1) % DEPTH; mCount--;
    end
  endtask

  function automatic logic [31:0] expStatus();
    return {8'(mRd), 8'(mWr), 15'b0, (mCount == DEPTH)};
  endfunction

  task automatic checkStatus(input string req);
    logic [31:0] d;
    readReg(6'h14, d);
    check(req, d, expStatus());
  endtask

  task automatic checkHead(input string req);
    logic [31:0] d;
    readReg(6'h00, d); check(req, d, 32'(mChan[mRd]));
    readReg(6'h04, d); check(req, d, mMsg[mRd][31:0]);
    readReg(6'h08, d); check(req, d, mMsg[mRd][63:32]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values, R8 depth
    readReg(6'h14, d); check("R1 status", d, 32'h0);
    readReg(6'h18, d); check("R1 irq status", d, 32'h0);
    readReg(6'h1C, d); check("R1 mask", d, 32'h1F);
    check("R1 irq pin", {31'b0, irq}, 32'h0);
    readReg(6'h24, d); check("R8 depth", d, 32'(DEPTH - 1));

    // R9 masked: no interrupt
    push();
    @(negedge clk); @(negedge clk);
    check("R9 masked irq", {31'b0, irq}, 32'h0);

    // R9 unmask, set one edge later
    writeReg(6'h1C, 32'h1E);
    readReg(6'h1C, d); check("R9 mask readback", d, 32'h1E);
    @(negedge clk);
    readReg(6'h18, d); check("R9 irq set", d, 32'h1);

    // R10 clear then re-set
    @(negedge clk);
    regAddr = 6'h18; regWrData = 32'h1; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R10 cleared", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 re-set", {31'b0, irq}, 32'h1);

    // R3 writing 0 to pop register has no effect
    writeReg(6'h0C, 32'h0);
    checkStatus("R3 zero write no pop");
    checkHead("R3 head kept");

    // R2/R4/R5/R6/R7 sweep with wrap
    for (int r = 0; r < 12; r++) begin
      int nPush = (r * 3) % (DEPTH + 3) + 1;
      int nPop = (r * 2) % (DEPTH + 2) + 1;
      for (int i = 0; i < nPush; i++) begin
        bit wasFull = (mCount == DEPTH);
        push();
        checkStatus(wasFull ? "R6 push when full" : "R4 push status");
        if (mCount == DEPTH) checkStatus("R5 full equal ptrs");
        if (wasFull) checkHead("R6 head unchanged");
      end
      for (int i = 0; i < nPop; i++) begin
        bit wasEmpty = (mCount == 0);
        if (!wasEmpty) checkHead("R2 head entry");
        pop();
        checkStatus(wasEmpty ? "R7 pop when empty" : "R3 pop status");
      end
    end

    // R11 flush
    while (mCount < 2) push();
    writeReg(6'h10, 32'h5);
    checkStatus("R11 nonzero flush ignored");
    @(negedge clk);
    check("R11 irq before flush", {31'b0, irq}, 32'h1);
    writeReg(6'h10, 32'h0);
    mWr = 0; mRd = 0; mCount = 0;
    checkStatus("R11 flush status");
    check("R11 flush irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R11 irq stays low", {31'b0, irq}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule